// File: doc/BRIEF.md
# Three-Identity I2C Target Engine

This block is the bit-level front end of an I2C target that can answer to three separate 7-bit bus addresses at once. Each identity has its own programming byte, with the address in the upper seven bits and an enable in bit 0. The engine oversamples SCL and SDA with the system clock and detects START, repeated START and STOP. It collects the address byte, picks the matching identity and acknowledges it. It then shifts write data in, or shifts read data out, one byte at a time. Byte storage sits outside the block. A received byte appears on a data port with a one-cycle strobe. A byte to be sent is taken from an input port when the engine pulses a load request.

When a transfer that moved at least one data byte ends at STOP or at a repeated START, the engine raises a one-cycle completion pulse. That pulse sets a read-done or write-done flag for the identity that was selected. The flags stay set until software writes 1 to clear them. Each flag has its own interrupt enable. Identities 1 and 2 share the low-priority interrupt line and identity 3 owns the high-priority line. A priority code names the most urgent pending identity.

Top module: `i2c_tri_slave`

## Requirements
- R1: Identity k (k = 1..3) uses byte k-1 of `slave_cfg_i`, with bits [7:1] as its address and bit 0 as its enable. When an address byte names an enabled identity, the engine pulls SDA low during the 9th SCL clock.
- R2: An address byte that names no enabled identity, or the general-call address 0, is not acknowledged. The engine then drives SDA never, produces no receive strobes and no load requests until the next START.
- R3: If several enabled identities hold the same address, the lowest-numbered one is selected.
- R4: Each byte written by the controller appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse, MSB received first, and is acknowledged.
- R5: In a read, each byte is taken from `tx_data_i` on a one-cycle `tx_load_o` pulse and sent MSB first. A controller ACK makes the engine load and send the next byte. A controller NACK ends the engine's driving of SDA.
- R6: A write transfer with at least one data byte sets the selected identity's write-done flag when it ends. An address-only transfer sets no flag.
- R7: A read transfer with at least one byte sets the selected identity's read-done flag when it ends.
- R8: Flag layout for `flag_clr_i`, `irq_mask_i`: bits [2:0] are read-done for identities 1..3 and bits [5:3] are write-done. Writing 1 to a clear bit clears that flag on the next cycle. A flag set in the same cycle as its clear stays set.
- R9: `irq_lo_o` is high while identity 1 or 2 has a flag set whose mask bit is 1. `irq_hi_o` does the same for identity 3.
- R10: `irq_id_o` gives 3 if identity 3 has an enabled pending flag, otherwise 1 if identity 1 has one, otherwise 2 if identity 2 has one, otherwise 0.
- R11: A repeated START ends the running transfer, including its flag update, and starts a new address phase.
- R12: During a transfer, `sel_slave_o` gives the selected identity (1..3) and `sel_read_o` gives the direction. After STOP, `sel_slave_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| slave_cfg_i | input | 24 | Per-identity address and enable bytes |
| tx_data_i | input | 8 | Byte to send, sampled on `tx_load_o` |
| tx_load_o | output | 1 | Request for the next read byte |
| rx_data_o | output | 8 | Last received write byte |
| rx_valid_o | output | 1 | Strobe for `rx_data_o` |
| sel_slave_o | output | 2 | Selected identity, 0 for none |
| sel_read_o | output | 1 | Direction of the current transfer, 1 for read |
| xfer_done_o | output | 1 | One-cycle end-of-transfer pulse |
| flag_clr_i | input | 6 | Write-1-to-clear strobes for the flags |
| irq_mask_i | input | 6 | Interrupt enables for the flags |
| rd_flag_o | output | 3 | Read-done flags, identities 1..3 |
| wr_flag_o | output | 3 | Write-done flags, identities 1..3 |
| irq_lo_o | output | 1 | Interrupt for identities 1 and 2 |
| irq_hi_o | output | 1 | Interrupt for identity 3 |
| irq_id_o | output | 2 | Highest-priority pending identity |

## Verification
The assertions assume a bus that is slow next to the system clock: SCL and SDA each hold for several clock cycles between changes, and SDA changes while SCL is high only to form START or STOP. They also assume the controller releases SDA whenever the target owns it, during address and data acknowledges and during read data bits. The bench's controller model spaces every edge by a quarter-bit of eight system clocks and releases its SDA output before each bit that the target drives. It resolves the line as an open-drain AND, so these assumptions hold at every step.

// File: rtl/i2c_ts_pkg.sv
package i2c_ts_pkg;
  localparam int NSLV  = 3;
  localparam int SEL_W = $clog2(NSLV + 1);
  localparam int CFG_W = 8 * NSLV;
  localparam int FLG_W = 2 * NSLV;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_SET, ST_ACK_HOLD, ST_WR_DATA,
    ST_RD_DATA, ST_RD_REL, ST_RD_MACK, ST_RD_NEXT, ST_IGNORE
  } eng_state_t;

  // Lowest-numbered enabled identity whose address equals adr; 0 if none.
  // Address 0 (general call) never matches.
  function automatic logic [SEL_W-1:0] pick_slave(input logic [CFG_W-1:0] cfg,
                                                  input logic [6:0] adr);
    pick_slave = '0;
    if (adr != 7'd0) begin
      for (int k = NSLV - 1; k >= 0; k--) begin
        if (cfg[8*k] && (cfg[8*k+1 +: 7] == adr)) pick_slave = SEL_W'(k + 1);
      end
    end
  endfunction

  // Last identity has top priority, then ascending order among the rest.
  function automatic logic [SEL_W-1:0] irq_pick(input logic [NSLV-1:0] pend);
    irq_pick = '0;
    for (int k = NSLV - 2; k >= 0; k--) begin
      if (pend[k]) irq_pick = SEL_W'(k + 1);
    end
    if (pend[NSLV-1]) irq_pick = SEL_W'(NSLV);
  endfunction
endpackage

// File: rtl/i2c_ts_line_sync.sv
module i2c_ts_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sr[STAGES-1];
  assign sda_s     = sda_sr[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ts_engine.sv
module i2c_ts_engine
  import i2c_ts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [7:0]       tx_data_i,
  output logic             sda_oe,
  output logic [SEL_W-1:0] sel,
  output logic             rd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             tx_load,
  output logic             done,
  output logic [SEL_W-1:0] done_sel,
  output logic             done_rd
);
  eng_state_t       state;
  logic [2:0]       bitcnt;
  logic [6:0]       sh;
  logic [7:0]       txsh;
  logic             seen;
  logic [SEL_W-1:0] addr_hit;

  assign addr_hit = pick_slave(cfg_i, sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      txsh     <= '0;
      seen     <= 1'b0;
      sda_oe   <= 1'b0;
      sel      <= '0;
      rd       <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      done     <= 1'b0;
      done_sel <= '0;
      done_rd  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      done     <= 1'b0;
      if (start_evt || stop_evt) begin
        done     <= (sel != '0) && seen;
        done_sel <= sel;
        done_rd  <= rd;
        seen     <= 1'b0;
        sda_oe   <= 1'b0;
        bitcnt   <= '0;
        sel      <= '0;
        rd       <= 1'b0;
        state    <= start_evt ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              if (addr_hit != '0) begin
                sel   <= addr_hit;
                rd    <= sda_s;
                state <= ST_ACK_SET;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              sh     <= {sh[5:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            bitcnt <= '0;
            if (rd) begin
              tx_load <= 1'b1;
              txsh    <= tx_data_i;
              sda_oe  <= ~tx_data_i[7];
              state   <= ST_RD_DATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR_DATA;
            end
          end
          ST_WR_DATA: if (scl_rise) begin
            sh <= {sh[5:0], sda_s};
            if (bitcnt == 3'd7) begin
              rx_data  <= {sh, sda_s};
              rx_valid <= 1'b1;
              seen     <= 1'b1;
              bitcnt   <= '0;
              state    <= ST_ACK_SET;
            end else begin
              bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_RD_DATA: begin
            if (scl_rise) begin
              if (bitcnt == 3'd7) begin
                bitcnt <= '0;
                state  <= ST_RD_REL;
              end else begin
                bitcnt <= bitcnt + 3'd1;
              end
            end else if (scl_fall) begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
          ST_RD_REL: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_RD_MACK;
          end
          ST_RD_MACK: if (scl_rise) begin
            seen  <= 1'b1;
            state <= sda_s ? ST_IGNORE : ST_RD_NEXT;
          end
          ST_RD_NEXT: if (scl_fall) begin
            tx_load <= 1'b1;
            txsh    <= tx_data_i;
            sda_oe  <= ~tx_data_i[7];
            state   <= ST_RD_DATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ts_flags.sv
module i2c_ts_flags
  import i2c_ts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [SEL_W-1:0] done_sel_i,
  input  logic             done_rd_i,
  input  logic [FLG_W-1:0] clr_i,
  input  logic [FLG_W-1:0] mask_i,
  output logic [NSLV-1:0]  rd_flag,
  output logic [NSLV-1:0]  wr_flag,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic [SEL_W-1:0] irq_id
);
  logic [NSLV-1:0] pend;

  for (genvar k = 0; k < NSLV; k++) begin : g_slv
    logic set_rd, set_wr, rd_f, wr_f;
    assign set_rd = done_i &&  done_rd_i && (done_sel_i == SEL_W'(k + 1));
    assign set_wr = done_i && !done_rd_i && (done_sel_i == SEL_W'(k + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_f <= 1'b0;
        wr_f <= 1'b0;
      end else begin
        if (set_rd)             rd_f <= 1'b1;
        else if (clr_i[k])      rd_f <= 1'b0;
        if (set_wr)             wr_f <= 1'b1;
        else if (clr_i[NSLV+k]) wr_f <= 1'b0;
      end
    end

    assign rd_flag[k] = rd_f;
    assign wr_flag[k] = wr_f;
    assign pend[k]    = (rd_f & mask_i[k]) | (wr_f & mask_i[NSLV+k]);
  end

  assign irq_hi = pend[NSLV-1];
  assign irq_lo = |pend[NSLV-2:0];
  assign irq_id = irq_pick(pend);
endmodule

// File: rtl/i2c_tri_slave.sv
module i2c_tri_slave
  import i2c_ts_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [CFG_W-1:0] slave_cfg_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_load_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic [SEL_W-1:0] sel_slave_o,
  output logic             sel_read_o,
  output logic             xfer_done_o,
  input  logic [FLG_W-1:0] flag_clr_i,
  input  logic [FLG_W-1:0] irq_mask_i,
  output logic [NSLV-1:0]  rd_flag_o,
  output logic [NSLV-1:0]  wr_flag_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o,
  output logic [SEL_W-1:0] irq_id_o
);
  logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             done_rd;
  logic [SEL_W-1:0] done_sel;

  i2c_ts_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_ts_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .cfg_i     (slave_cfg_i),
    .tx_data_i (tx_data_i),
    .sda_oe    (sda_oe_o),
    .sel       (sel_slave_o),
    .rd        (sel_read_o),
    .rx_data   (rx_data_o),
    .rx_valid  (rx_valid_o),
    .tx_load   (tx_load_o),
    .done      (xfer_done_o),
    .done_sel  (done_sel),
    .done_rd   (done_rd)
  );

  i2c_ts_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (xfer_done_o),
    .done_sel_i (done_sel),
    .done_rd_i  (done_rd),
    .clr_i      (flag_clr_i),
    .mask_i     (irq_mask_i),
    .rd_flag    (rd_flag_o),
    .wr_flag    (wr_flag_o),
    .irq_lo     (irq_lo_o),
    .irq_hi     (irq_hi_o),
    .irq_id     (irq_id_o)
  );
endmodule

// File: rtl/i2c_ts_checker.sv
module i2c_ts_checker
  import i2c_ts_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic [SEL_W-1:0] sel,
  input logic             rd,
  input logic             rx_valid,
  input logic             tx_load,
  input logic             done,
  input logic [SEL_W-1:0] done_sel,
  input logic             done_rd,
  input logic             stop_evt,
  input logic [FLG_W-1:0] flag_clr,
  input logic [NSLV-1:0]  rd_flag,
  input logic [NSLV-1:0]  wr_flag,
  input logic             irq_hi,
  input logic [SEL_W-1:0] irq_id
);
  assert_drive_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (sel != '0));

  assert_no_rx_unmatched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((sel != '0) && !rd));

  assert_load_only_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> ((sel != '0) && rd));

  for (genvar k = 0; k < NSLV; k++) begin : g_chk
    assert_wr_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_rd && done_sel == SEL_W'(k + 1)) |=> wr_flag[k]);

    assert_rd_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_rd && done_sel == SEL_W'(k + 1)) |=> rd_flag[k]);

    assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[k] && !(done && done_rd && done_sel == SEL_W'(k + 1))) |=> !rd_flag[k]);
  end

  assert_irq_hi_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> (rd_flag[NSLV-1] || wr_flag[NSLV-1]));

  assert_irq_id_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (irq_id == SEL_W'(NSLV)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_sel_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (sel == '0));
endmodule

bind i2c_tri_slave i2c_ts_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe_o),
  .sel      (sel_slave_o),
  .rd       (sel_read_o),
  .rx_valid (rx_valid_o),
  .tx_load  (tx_load_o),
  .done     (xfer_done_o),
  .done_sel (done_sel),
  .done_rd  (done_rd),
  .stop_evt (stop_evt),
  .flag_clr (flag_clr_i),
  .rd_flag  (rd_flag_o),
  .wr_flag  (wr_flag_o),
  .irq_hi   (irq_hi_o),
  .irq_id   (irq_id_o)
);

// File: tb/test_i2c_tri_slave.sv
module test_i2c_tri_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [23:0] cfg = '0;
  logic [7:0]  tx_data;
  logic        tx_load, rx_valid, sel_read, xfer_done, irq_lo, irq_hi;
  logic [7:0]  rx_data;
  logic [1:0]  sel_slave, irq_id;
  logic [5:0]  flag_clr = '0;
  logic [5:0]  irq_mask = '0;
  logic [2:0]  rd_flag, wr_flag;
  wire         sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int ld_cnt = 0;
  int rx_n = 0;
  int oe_cnt = 0;
  logic [7:0] rx_log [16];

  always #10 clk = ~clk;

  function automatic logic [7:0] txpat(input int n);
    return 8'h5A + 8'(n) * 8'h3B;
  endfunction

  assign tx_data = txpat(ld_cnt);

  i2c_tri_slave i_i2c_tri_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .slave_cfg_i(cfg), .tx_data_i(tx_data), .tx_load_o(tx_load),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .sel_slave_o(sel_slave),
    .sel_read_o(sel_read), .xfer_done_o(xfer_done), .flag_clr_i(flag_clr),
    .irq_mask_i(irq_mask), .rd_flag_o(rd_flag), .wr_flag_o(wr_flag),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .irq_id_o(irq_id)
  );

  always @(negedge clk) begin
    if (tx_load) ld_cnt <= ld_cnt + 1;
    if (rx_valid) begin
      if (rx_n < 16) rx_log[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n * Q) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); @(negedge clk); b = sda_bus;
    wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(mack);
  endtask

  task automatic settle(); repeat (12) @(posedge clk); @(negedge clk); endtask

  function automatic logic [23:0] mkcfg(input logic [6:0] a1, input logic e1,
                                        input logic [6:0] a2, input logic e2,
                                        input logic [6:0] a3, input logic e3);
    return {a3, e3, a2, e2, a1, e1};
  endfunction

  task automatic clear_all();
    @(negedge clk); flag_clr = 6'h3F; @(negedge clk); flag_clr = '0; @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!sda_oe && sel_slave == 0 && !irq_lo && !irq_hi, "reset R12", {sel_slave, sda_oe}, 0);
    chk(rd_flag == 0 && wr_flag == 0 && irq_id == 0, "reset flags R8", {rd_flag, wr_flag}, 0);
  endtask

  task automatic t_write();
    logic ack; int base;
    base = rx_n;
    bus_start();
    put_byte({7'h51, 1'b0}, ack);
    chk(ack == 1'b0, "R1 address ack", ack, 0);
    chk(sel_slave == 2 && !sel_read, "R12 select write", {sel_slave, sel_read}, 4);
    put_byte(8'hC4, ack);
    chk(ack == 1'b0, "R4 data ack", ack, 0);
    put_byte(8'h19, ack);
    bus_stop(); settle();
    chk(rx_n == base + 2, "R4 byte count", rx_n - base, 2);
    chk(rx_log[base] == 8'hC4 && rx_log[base+1] == 8'h19, "R4 data", {rx_log[base], rx_log[base+1]}, 16'hC419);
    chk(wr_flag == 3'b010 && rd_flag == 0, "R6 write flag", wr_flag, 2);
    chk(sel_slave == 0, "R12 idle after stop", sel_slave, 0);
    chk(irq_lo && !irq_hi, "R9 low line", {irq_lo, irq_hi}, 2);
    chk(irq_id == 2, "R10 id slave2", irq_id, 2);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] d0, d1; int l0;
    l0 = ld_cnt;
    bus_start();
    put_byte({7'h52, 1'b1}, ack);
    chk(ack == 1'b0 && sel_slave == 3 && sel_read, "R12 select read", {sel_slave, sel_read}, 7);
    get_byte(1'b0, d0);
    get_byte(1'b1, d1);
    chk(d0 == txpat(l0), "R5 first byte", d0, txpat(l0));
    chk(d1 == txpat(l0 + 1), "R5 second byte", d1, txpat(l0 + 1));
    chk(ld_cnt == l0 + 2 && !sda_oe, "R5 stop after nack", ld_cnt - l0, 2);
    bus_stop(); settle();
    chk(rd_flag == 3'b100, "R7 read flag", rd_flag, 4);
    chk(irq_hi && irq_lo, "R9 both lines", {irq_lo, irq_hi}, 3);
    chk(irq_id == 3, "R10 id slave3 wins", irq_id, 3);
  endtask

  task automatic t_clear();
    @(negedge clk); flag_clr = 6'b000_100; @(negedge clk); flag_clr = '0; @(negedge clk);
    chk(rd_flag == 0 && wr_flag == 3'b010, "R8 single clear", {rd_flag, wr_flag}, 2);
    chk(!irq_hi && irq_id == 2, "R10 id after clear", irq_id, 2);
    clear_all();
    chk(wr_flag == 0 && !irq_lo, "R8 all cleared", wr_flag, 0);
  endtask

  task automatic t_nomatch(input logic [6:0] a, input string tag);
    logic ack; int base, oe0;
    base = rx_n; oe0 = oe_cnt;
    bus_start();
    put_byte({a, 1'b0}, ack);
    put_byte(8'h00, ack);
    bus_stop(); settle();
    chk(oe_cnt == oe0 && rx_n == base, tag, oe_cnt - oe0, 0);
    chk(wr_flag == 0 && rd_flag == 0, "R2 no flag", wr_flag, 0);
  endtask

  task automatic t_zero();
    logic ack;
    bus_start();
    put_byte({7'h50, 1'b0}, ack);
    chk(ack == 1'b0, "R1 address ack slave1", ack, 0);
    bus_stop(); settle();
    chk(wr_flag == 0 && !xfer_done, "R6 address only", wr_flag, 0);
  endtask

  task automatic t_dup();
    logic ack;
    cfg = mkcfg(7'h50, 1'b1, 7'h52, 1'b1, 7'h52, 1'b1);
    bus_start();
    put_byte({7'h52, 1'b0}, ack);
    chk(sel_slave == 2, "R3 lowest wins", sel_slave, 2);
    put_byte(8'h77, ack);
    bus_stop(); settle();
    chk(wr_flag == 3'b010, "R3 flag owner", wr_flag, 2);
    clear_all();
    cfg = mkcfg(7'h50, 1'b1, 7'h51, 1'b1, 7'h52, 1'b1);
  endtask

  task automatic t_restart();
    logic ack; logic [7:0] d; int l0;
    bus_start();
    put_byte({7'h50, 1'b0}, ack);
    put_byte(8'h2E, ack);
    bus_start();
    settle();
    chk(wr_flag == 3'b001 && rd_flag == 0, "R11 flag at restart", wr_flag, 1);
    l0 = ld_cnt;
    put_byte({7'h50, 1'b1}, ack);
    chk(ack == 1'b0 && sel_read, "R11 new address phase", sel_read, 1);
    get_byte(1'b1, d);
    chk(d == txpat(l0), "R5 read after restart", d, txpat(l0));
    bus_stop(); settle();
    chk(rd_flag == 3'b001, "R7 read flag slave1", rd_flag, 1);
    irq_mask = 6'b000_110; @(negedge clk);
    chk(!irq_lo && irq_id == 0, "R9 masked", irq_lo, 0);
    irq_mask = 6'b001_000; @(negedge clk);
    chk(irq_lo && irq_id == 1, "R10 id slave1", irq_id, 1);
    irq_mask = 6'h3F;
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    cfg = mkcfg(7'h50, 1'b1, 7'h51, 1'b1, 7'h52, 1'b1);
    irq_mask = 6'h3F;
    repeat (4) @(posedge clk);
    t_write();
    t_read();
    t_clear();
    t_nomatch(7'h33, "R2 unknown address");
    cfg = mkcfg(7'h50, 1'b0, 7'h51, 1'b1, 7'h52, 1'b1);
    t_nomatch(7'h50, "R2 disabled identity");
    cfg = mkcfg(7'h00, 1'b1, 7'h51, 1'b1, 7'h52, 1'b1);
    t_nomatch(7'h00, "R2 general call");
    cfg = mkcfg(7'h50, 1'b1, 7'h51, 1'b1, 7'h52, 1'b1);
    t_zero();
    t_dup();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule